// File: doc/BRIEF.md
# Bridge Configuration Header Shadow

This block sits between a configuration-access master and a root-port function whose own configuration space does not follow the standard bridge layout. It presents a clean Type 1 bridge header to the master. The dwords from byte offset 0x10 to 0x33 of the bridge's header are kept in a local shadow of nine dwords and never touch the function's own registers. Reads of the dword that holds the header type come back with the layout code forced to the bridge value. The expansion ROM base dword is moved to the offset the function actually implements. Writes to the bus-number dword are captured, and the secondary bus number is driven out as the local bus number for the port hardware.

The bridge sits on the primary bus, which resets to bus 0, as device 0 and function 0. Any other device or function number on the primary bus is refused. Accesses to the bridge that the shadow does not serve are sent downstream to the secondary bus number as device 1, function 0. Accesses to other bus numbers pass through unchanged.

Both the upstream port and the downstream port carry a request channel and a response channel, each using valid/ready. A source keeps valid and every payload field steady until the cycle in which ready is high. The block holds one transaction at a time. It lowers `up_req_ready` from the moment it accepts a request until the response has been taken. Holding `up_rsp_ready` low stalls the block without losing data. Every request, read or write, produces exactly one upstream response and at most one downstream transaction.

Top module: `cfg_bridge_shadow`

## Requirements
- R1: After reset the block shows `up_req_ready`=1, `up_rsp_valid`=0, `dn_req_valid`=0 and `local_bus`=0. The primary and secondary bus numbers are both 0. The shadow dword at 0x1C reads 0x0000_0101 (32-bit I/O in base and limit), the shadow dword at 0x24 reads 0x0001_0001 (64-bit prefetchable in base and limit), and all other shadow dwords read 0.
- R2: On the primary bus, device 0, function 0, any access to dword addresses 4 to 12 (bytes 0x10 to 0x33) is served from the shadow, and no downstream request is issued.
- R3: A write to dword 4 or dword 5 (0x10, 0x14) leaves that shadow dword at 0.
- R4: A shadow write changes only the bytes whose enable is set. `be[i]` selects data bits 8i+7:8i.
- R5: A read response carries only the enabled lanes, shifted down so that the lowest enabled lane lands at bits 7:0. The disabled lanes read as zero. Write responses carry 0.
- R6: A shadow write to dword 6 (0x18) with `be[0]` set replaces the primary bus number with byte 0 of the data. Later accesses carrying that bus number are treated as primary-bus accesses.
- R7: A shadow write to dword 6 with `be[1]` set replaces the secondary bus number with byte 1 of the data. From the next cycle, `local_bus` shows that value.
- R8: A primary-bus access to device 0, function 0 that the shadow does not serve is forwarded downstream. It goes to bus = secondary number, device 1, function 0, with the same write flag, byte enables and write data.
- R9: On the primary bus, dword 14 (0x38) is forwarded as dword 12 (0x30). Other dword addresses are forwarded unchanged.
- R10: On a primary-bus read of dword 3 (0x0C), bits 22:16 of the downstream data are replaced with 0x01, and all other bits, including bit 23, are kept. The replacement happens before lane selection.
- R11: A primary-bus access with a nonzero device or function number is refused. A read returns all ones in its enabled lanes, after the shift. A write is dropped. Neither reaches downstream, and neither changes the shadow.
- R12: An access to any bus other than the primary bus is forwarded with its own bus, device, function and dword address, with no relocation and no header-type change.
- R13: While `up_rsp_valid` is high and `up_rsp_ready` is low, the response stays valid and its data does not change. `up_req_ready` is low whenever a response is pending. `dn_req_valid` stays high with steady fields until `dn_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request ready (high only when idle) |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_bus | input | 8 | Target bus number |
| up_req_dev | input | DEV_W | Target device number |
| up_req_fn | input | FN_W | Target function number |
| up_req_dwa | input | DWA_W | Dword address (byte offset / 4) |
| up_req_be | input | 4 | Byte enables, bit i = bits 8i+7:8i |
| up_req_wdata | input | 32 | Write data, dword aligned |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Upstream response ready |
| up_rsp_data | output | 32 | Read data, lanes shifted to bit 0; 0 for writes |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request ready |
| dn_req_write | output | 1 | Downstream write flag |
| dn_req_bus | output | 8 | Downstream bus number |
| dn_req_dev | output | DEV_W | Downstream device number |
| dn_req_fn | output | FN_W | Downstream function number |
| dn_req_dwa | output | DWA_W | Downstream dword address |
| dn_req_be | output | 4 | Downstream byte enables |
| dn_req_wdata | output | 32 | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream completion valid |
| dn_rsp_ready | output | 1 | Downstream completion ready |
| dn_rsp_data | input | 32 | Downstream read data, dword aligned |
| local_bus | output | 8 | Local bus number for the port hardware (secondary bus) |

## Verification
The bench builds the block with its default parameters: a 10-bit dword address, a 5-bit device field and a 3-bit function field. With the 10-bit address it can reach dwords past the end of the header, such as 0x40, which shows plain forwarding beside the shadow window, the relocated ROM dword and the patched header dword. The full-width device and function fields let it pick nonzero device and function numbers on the primary bus and so exercise the refusal path. It moves both bus numbers away from zero, so that bus 0 stops being primary and forwarded accesses carry a nonzero secondary number.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int BUS_W     = 8;
  localparam int LANES     = 4;
  localparam int DATA_W    = 8 * LANES;
  localparam int SH_FIRST  = 4;   // dword of byte 0x10
  localparam int SH_CNT    = 9;   // dwords 0x10..0x33
  localparam int SH_BAR_N  = 2;   // leading shadow dwords that always hold zero
  localparam int SH_BUSNUM = 2;   // shadow index of dword 0x18
  localparam int SH_IO     = 3;   // shadow index of dword 0x1C
  localparam int SH_PREF   = 5;   // shadow index of dword 0x24
  localparam int DWA_HDR   = 3;   // dword 0x0C
  localparam int DWA_ROM_V = 14;  // dword 0x38 seen upstream
  localparam int DWA_ROM_R = 12;  // dword 0x30 in the function

  typedef enum logic [1:0] {ST_IDLE, ST_DREQ, ST_DWAIT, ST_RESP} cbs_state_e;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] lane_pick(input logic [DATA_W-1:0] d,
                                                  input logic [LANES-1:0] be);
    logic [DATA_W-1:0] m;
    m = d & lane_mask(be);
    if (be[0])      return m;
    else if (be[1]) return m >> 8;
    else if (be[2]) return m >> 16;
    else            return m >> 24;
  endfunction

  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old,
                                                   input logic [DATA_W-1:0] nw,
                                                   input logic [LANES-1:0] be);
    return (old & ~lane_mask(be)) | (nw & lane_mask(be));
  endfunction

  function automatic logic [DATA_W-1:0] shadow_init(input int k);
    if (k == SH_IO)   return 32'h0000_0101;
    if (k == SH_PREF) return 32'h0001_0001;
    return '0;
  endfunction
endpackage

// File: rtl/cbs_shadow.sv
module cbs_shadow
  import cbs_pkg::*;
#(
  parameter int N  = SH_CNT,
  localparam int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     idx,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [BUS_W-1:0]  prim_bus,
  output logic [BUS_W-1:0]  sec_bus
);
  logic [DATA_W-1:0] arr [N];

  for (genvar k = 0; k < N; k++) begin : g_ent
    if (k < SH_BAR_N) begin : g_bar
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) arr[k] <= '0;
        else if (wr_en && idx == IW'(k)) arr[k] <= '0;
    end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) arr[k] <= shadow_init(k);
        else if (wr_en && idx == IW'(k)) arr[k] <= lane_merge(arr[k], wdata, be);
    end
  end

  assign rd_data  = (idx < IW'(N)) ? arr[idx] : '0;
  assign prim_bus = arr[SH_BUSNUM][7:0];
  assign sec_bus  = arr[SH_BUSNUM][15:8];

  // R6
  prim_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IW'(SH_BUSNUM) && be[0]) |=> prim_bus == $past(wdata[7:0]));
  // R7
  sec_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IW'(SH_BUSNUM) && be[1]) |=> sec_bus == $past(wdata[15:8]));
endmodule

// File: rtl/cbs_decode.sv
module cbs_decode
  import cbs_pkg::*;
#(
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int DWA_W = 10,
  localparam int IW   = $clog2(SH_CNT)
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  input  logic [FN_W-1:0]  fn,
  input  logic [DWA_W-1:0] dwa,
  input  logic [BUS_W-1:0] prim_bus,
  input  logic [BUS_W-1:0] sec_bus,
  output logic             is_prim,
  output logic             refused,
  output logic             shadow_hit,
  output logic [IW-1:0]    shadow_idx,
  output logic             hdr_fix,
  output logic [BUS_W-1:0] fwd_bus,
  output logic [DEV_W-1:0] fwd_dev,
  output logic [FN_W-1:0]  fwd_fn,
  output logic [DWA_W-1:0] fwd_dwa
);
  localparam logic [DWA_W-1:0] LO   = DWA_W'(SH_FIRST);
  localparam logic [DWA_W-1:0] HI   = DWA_W'(SH_FIRST + SH_CNT);
  localparam logic [DWA_W-1:0] HDR  = DWA_W'(DWA_HDR);
  localparam logic [DWA_W-1:0] ROMV = DWA_W'(DWA_ROM_V);
  localparam logic [DWA_W-1:0] ROMR = DWA_W'(DWA_ROM_R);

  logic [DWA_W-1:0] rel;

  always_comb begin
    is_prim    = (bus == prim_bus);
    refused    = is_prim && (dev != '0 || fn != '0);
    shadow_hit = is_prim && !refused && dwa >= LO && dwa < HI;
    rel        = dwa - LO;
    shadow_idx = rel[IW-1:0];
    hdr_fix    = is_prim && dwa == HDR;
    if (is_prim) begin
      fwd_bus = sec_bus;
      fwd_dev = DEV_W'(1);
      fwd_fn  = '0;
      fwd_dwa = (dwa == ROMV) ? ROMR : dwa;
    end else begin
      fwd_bus = bus;
      fwd_dev = dev;
      fwd_fn  = fn;
      fwd_dwa = dwa;
    end
  end
endmodule

// File: rtl/cbs_rsp_fix.sv
module cbs_rsp_fix
  import cbs_pkg::*;
(
  input  logic [DATA_W-1:0] raw,
  input  logic              hdr_fix,
  input  logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] data
);
  logic [DATA_W-1:0] patched;
  always_comb begin
    patched = hdr_fix ? {raw[31:23], 7'h01, raw[15:0]} : raw;
    data    = lane_pick(patched, be);
  end
endmodule

// File: rtl/cfg_bridge_shadow.sv
module cfg_bridge_shadow
  import cbs_pkg::*;
#(
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int DWA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic              up_req_write,
  input  logic [BUS_W-1:0]  up_req_bus,
  input  logic [DEV_W-1:0]  up_req_dev,
  input  logic [FN_W-1:0]   up_req_fn,
  input  logic [DWA_W-1:0]  up_req_dwa,
  input  logic [LANES-1:0]  up_req_be,
  input  logic [DATA_W-1:0] up_req_wdata,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic [DATA_W-1:0] up_rsp_data,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic              dn_req_write,
  output logic [BUS_W-1:0]  dn_req_bus,
  output logic [DEV_W-1:0]  dn_req_dev,
  output logic [FN_W-1:0]   dn_req_fn,
  output logic [DWA_W-1:0]  dn_req_dwa,
  output logic [LANES-1:0]  dn_req_be,
  output logic [DATA_W-1:0] dn_req_wdata,
  input  logic              dn_rsp_valid,
  output logic              dn_rsp_ready,
  input  logic [DATA_W-1:0] dn_rsp_data,
  output logic [BUS_W-1:0]  local_bus
);
  localparam int IW = $clog2(SH_CNT);

  cbs_state_e        state;
  logic              accept, is_prim, refused, shadow_hit, hdr_fix, sh_wr;
  logic [IW-1:0]     shadow_idx;
  logic [BUS_W-1:0]  prim_bus, sec_bus, fwd_bus;
  logic [DEV_W-1:0]  fwd_dev;
  logic [FN_W-1:0]   fwd_fn;
  logic [DWA_W-1:0]  fwd_dwa;
  logic [DATA_W-1:0] sh_rd, dn_fixed;
  logic              r_fix, r_prim;

  assign up_req_ready = (state == ST_IDLE);
  assign up_rsp_valid = (state == ST_RESP);
  assign dn_req_valid = (state == ST_DREQ);
  assign dn_rsp_ready = (state == ST_DWAIT);
  assign local_bus    = sec_bus;
  assign accept       = up_req_valid && up_req_ready;
  assign sh_wr        = accept && shadow_hit && up_req_write;

  cbs_decode #(.DEV_W(DEV_W), .FN_W(FN_W), .DWA_W(DWA_W)) u_dec (
    .bus(up_req_bus), .dev(up_req_dev), .fn(up_req_fn), .dwa(up_req_dwa),
    .prim_bus(prim_bus), .sec_bus(sec_bus),
    .is_prim(is_prim), .refused(refused), .shadow_hit(shadow_hit),
    .shadow_idx(shadow_idx), .hdr_fix(hdr_fix),
    .fwd_bus(fwd_bus), .fwd_dev(fwd_dev), .fwd_fn(fwd_fn), .fwd_dwa(fwd_dwa));

  cbs_shadow #(.N(SH_CNT)) u_sh (
    .clk(clk), .rst_n(rst_n), .wr_en(sh_wr), .idx(shadow_idx),
    .be(up_req_be), .wdata(up_req_wdata), .rd_data(sh_rd),
    .prim_bus(prim_bus), .sec_bus(sec_bus));

  cbs_rsp_fix u_fix (.raw(dn_rsp_data), .hdr_fix(r_fix), .be(dn_req_be), .data(dn_fixed));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      up_rsp_data  <= '0;
      dn_req_write <= 1'b0;
      dn_req_bus   <= '0;
      dn_req_dev   <= '0;
      dn_req_fn    <= '0;
      dn_req_dwa   <= '0;
      dn_req_be    <= '0;
      dn_req_wdata <= '0;
      r_fix        <= 1'b0;
      r_prim       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          if (refused) begin
            up_rsp_data <= up_req_write ? '0 : lane_pick('1, up_req_be);
            state       <= ST_RESP;
          end else if (shadow_hit) begin
            up_rsp_data <= up_req_write ? '0 : lane_pick(sh_rd, up_req_be);
            state       <= ST_RESP;
          end else begin
            dn_req_write <= up_req_write;
            dn_req_bus   <= fwd_bus;
            dn_req_dev   <= fwd_dev;
            dn_req_fn    <= fwd_fn;
            dn_req_dwa   <= fwd_dwa;
            dn_req_be    <= up_req_be;
            dn_req_wdata <= up_req_wdata;
            r_fix        <= hdr_fix && !up_req_write;
            r_prim       <= is_prim;
            state        <= ST_DREQ;
          end
        end
        ST_DREQ:  if (dn_req_ready) state <= ST_DWAIT;
        ST_DWAIT: if (dn_rsp_valid) begin
          up_rsp_data <= dn_req_write ? '0 : dn_fixed;
          state       <= ST_RESP;
        end
        ST_RESP:  if (up_rsp_ready) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R13
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && !up_rsp_ready) |=> (up_rsp_valid && $stable(up_rsp_data)));
  // R13
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && !dn_req_ready) |=> (dn_req_valid && $stable(dn_req_dwa) && $stable(dn_req_bus)));
  // R2
  shadow_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && shadow_hit) |=> (!dn_req_valid && up_rsp_valid));
  // R11
  refuse_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && refused) |=> (!dn_req_valid && up_rsp_valid));
  // R8
  prim_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && r_prim) |-> (dn_req_bus == sec_bus && dn_req_dev == DEV_W'(1) && dn_req_fn == '0));
endmodule

// File: tb/cfg_bridge_shadow_test.sv
module cfg_bridge_shadow_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic up_req_valid = 0, up_req_write = 0, up_rsp_ready = 0;
  logic [7:0]  up_req_bus = 0;
  logic [4:0]  up_req_dev = 0;
  logic [2:0]  up_req_fn = 0;
  logic [9:0]  up_req_dwa = 0;
  logic [3:0]  up_req_be = 0;
  logic [31:0] up_req_wdata = 0;
  logic up_req_ready, up_rsp_valid;
  logic [31:0] up_rsp_data;
  logic dn_req_valid, dn_req_write, dn_rsp_ready;
  logic dn_req_ready = 0, dn_rsp_valid = 0;
  logic [31:0] dn_rsp_data = 0;
  logic [7:0]  dn_req_bus, local_bus;
  logic [4:0]  dn_req_dev;
  logic [2:0]  dn_req_fn;
  logic [9:0]  dn_req_dwa;
  logic [3:0]  dn_req_be;
  logic [31:0] dn_req_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_bridge_shadow uut (.*);

  int tests = 0, fails = 0, dn_seen = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] dn_exp_q[$];
  string       dn_tag_q[$];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] dn_value(logic [9:0] a);
    return 32'hC3A5_0000 | {22'b0, a};
  endfunction

  function automatic logic [63:0] dn_pack(bit wr, logic [7:0] b, logic [4:0] d,
                                          logic [2:0] f, logic [9:0] a,
                                          logic [3:0] be, logic [31:0] wd);
    return {1'b0, wr, b, d, f, a, be, (wr ? wd : 32'h0)};
  endfunction

  task automatic expect_dn(bit wr, logic [7:0] b, logic [4:0] d, logic [2:0] f,
                           logic [9:0] a, logic [3:0] be, logic [31:0] wd, string tag);
    dn_exp_q.push_back(dn_pack(wr, b, d, f, a, be, wd));
    dn_tag_q.push_back(tag);
  endtask

  task automatic send(bit wr, logic [7:0] b, logic [4:0] d, logic [2:0] f,
                      logic [9:0] a, logic [3:0] be, logic [31:0] wd,
                      logic [31:0] expv, string tag);
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    @(negedge clk);
    up_req_valid = 1; up_req_write = wr; up_req_bus = b; up_req_dev = d;
    up_req_fn = f; up_req_dwa = a; up_req_be = be; up_req_wdata = wd;
    #1;
    while (!up_req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    up_req_valid = 0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // response monitor / scoreboard with back-pressure
  initial begin
    int cyc = 0;
    bit held = 0;
    logic [31:0] held_d = 0;
    forever begin
      @(negedge clk);
      up_rsp_ready = (cyc % 4 != 1);
      cyc++;
      #1;
      if (rst_n && up_rsp_valid) begin
        if (held) chk(up_rsp_data == held_d, "R13 hold", up_rsp_data, held_d);
        chk(!up_req_ready, "R13 busy", up_req_ready, 0);
        if (up_rsp_ready) begin
          held = 0;
          if (exp_q.size() == 0) chk(0, "R13 unexpected rsp", up_rsp_data, 0);
          else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(up_rsp_data == e, t, up_rsp_data, e);
          end
        end else begin
          held = 1; held_d = up_rsp_data;
        end
      end else held = 0;
    end
  end

  // downstream responder / checker
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      dn_req_ready = (cyc % 3 != 0);
      cyc++;
      #1;
      if (rst_n && dn_req_valid && dn_req_ready) begin
        logic [63:0] act;
        logic [9:0] a;
        act = dn_pack(dn_req_write, dn_req_bus, dn_req_dev, dn_req_fn,
                      dn_req_dwa, dn_req_be, dn_req_wdata);
        a = dn_req_dwa;
        dn_seen++;
        if (dn_exp_q.size() == 0) chk(0, "R2/R11 unexpected downstream", act, 0);
        else begin
          logic [63:0] e;
          string t;
          e = dn_exp_q.pop_front();
          t = dn_tag_q.pop_front();
          chk(act == e, t, act, e);
        end
        @(negedge clk);
        dn_req_ready = 0;
        @(negedge clk);
        dn_rsp_valid = 1;
        dn_rsp_data = dn_value(a);
        @(negedge clk);
        dn_rsp_valid = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(up_req_ready && !up_rsp_valid && !dn_req_valid && local_bus == 0, "R1 reset",
        {up_req_ready, up_rsp_valid, dn_req_valid, local_bus}, {1'b1, 1'b0, 1'b0, 8'h00});

    n0 = dn_seen;
    send(0, 0, 0, 0, 10'd7, 4'hF, 0, 32'h0000_0101, "R1 io default");
    send(0, 0, 0, 0, 10'd9, 4'hF, 0, 32'h0001_0001, "R1 pref default");
    send(1, 0, 0, 0, 10'd4, 4'hF, 32'hFFFF_FFFF, 0, "R5 write rsp");
    send(1, 0, 0, 0, 10'd5, 4'hF, 32'h1234_5678, 0, "R5 write rsp");
    send(0, 0, 0, 0, 10'd4, 4'hF, 0, 0, "R3 bar0 zero");
    send(0, 0, 0, 0, 10'd5, 4'hF, 0, 0, "R3 bar1 zero");
    send(1, 0, 0, 0, 10'd8, 4'hF, 32'h1122_3344, 0, "R5 write rsp");
    send(1, 0, 0, 0, 10'd8, 4'b0100, 32'hAABB_CCDD, 0, "R5 write rsp");
    send(0, 0, 0, 0, 10'd8, 4'hF, 0, 32'h11BB_3344, "R4 lane merge");
    send(0, 0, 0, 0, 10'd8, 4'b0100, 0, 32'h0000_00BB, "R5 byte lane");
    send(0, 0, 0, 0, 10'd8, 4'b1100, 0, 32'h0000_11BB, "R5 half lane");
    chk(dn_seen == n0, "R2 no downstream", dn_seen, n0);

    send(1, 0, 0, 0, 10'd6, 4'b0011, 32'h0000_0702, 0, "R6 write rsp");
    chk(local_bus == 8'h07, "R7 local bus", local_bus, 8'h07);
    expect_dn(0, 8'd7, 5'd1, 3'd0, 10'd3, 4'hF, 0, "R8 primary route");
    send(0, 8'd2, 0, 0, 10'd3, 4'hF, 0, 32'hC381_0003, "R10 header fix");
    expect_dn(0, 8'd0, 5'd0, 3'd0, 10'd3, 4'hF, 0, "R6 bus0 no longer primary");
    send(0, 8'd0, 0, 0, 10'd3, 4'hF, 0, 32'hC3A5_0003, "R6 bus0 passthrough");

    send(1, 8'd2, 0, 0, 10'd6, 4'b0010, 32'h0000_0900, 0, "R7 write rsp");
    chk(local_bus == 8'h09, "R7 local bus update", local_bus, 8'h09);
    send(0, 8'd2, 0, 0, 10'd6, 4'hF, 0, 32'h0000_0902, "R6 shadow keeps primary");

    expect_dn(0, 8'd9, 5'd1, 3'd0, 10'd12, 4'hF, 0, "R9 rom relocate");
    send(0, 8'd2, 0, 0, 10'd14, 4'hF, 0, 32'hC3A5_000C, "R9 rom data");
    expect_dn(1, 8'd9, 5'd1, 3'd0, 10'h40, 4'b0011, 32'h0000_1234, "R8 write forward");
    send(1, 8'd2, 0, 0, 10'h40, 4'b0011, 32'h0000_1234, 0, "R8 write rsp");
    expect_dn(0, 8'd9, 5'd1, 3'd0, 10'd3, 4'b0100, 0, "R8 byte route");
    send(0, 8'd2, 0, 0, 10'd3, 4'b0100, 0, 32'h0000_0081, "R10 header byte");

    n0 = dn_seen;
    send(0, 8'd2, 5'd3, 0, 10'd0, 4'b0011, 0, 32'h0000_FFFF, "R11 refused read");
    send(1, 8'd2, 0, 3'd1, 10'd8, 4'hF, 32'h0, 0, "R11 refused write rsp");
    send(0, 8'd2, 0, 0, 10'd8, 4'hF, 0, 32'h11BB_3344, "R11 shadow untouched");
    chk(dn_seen == n0, "R11 no downstream", dn_seen, n0);

    expect_dn(0, 8'd9, 5'd0, 3'd0, 10'd3, 4'hF, 0, "R12 other bus");
    send(0, 8'd9, 0, 0, 10'd3, 4'hF, 0, 32'hC3A5_0003, "R12 no header fix");
    expect_dn(0, 8'd5, 5'd4, 3'd2, 10'd14, 4'hF, 0, "R12 no relocate");
    send(0, 8'd5, 5'd4, 3'd2, 10'd14, 4'hF, 0, 32'hC3A5_000E, "R12 data");

    repeat (5) @(negedge clk);
    chk(dn_exp_q.size() == 0, "R8 all downstream seen", dn_exp_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule